// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out the instruction that sets the vector length of a vector-capable core. It holds three state registers: the active vector length (VL), the upper limit on that length (MVL) and a small STATE word. Each accepted instruction arrives as pre-extracted fields: the 7-bit immediate, the source and destination register indices, and the value read from the source register. The unit updates its state from these fields, returns the new length for write-back to the destination register, or flags the instruction as illegal.

The instruction form follows from the two register indices. When both are zero, only MVL is set from the immediate. When the source index is zero and the destination index is not, both lengths are set from the immediate. A nonzero source index selects register mode, in which the requested length is limited to MVL. Immediate lengths are offset by one, so the immediate form can never produce a zero length. A separate special-register write port can load any value, including zero, and it overrides an instruction update made in the same cycle.

Top module: `vlset_unit`

## Requirements
- R1: After reset VL = 1, MVL = 1, STATE = 0, and neither the write-back strobe nor the illegal flag is asserted.
- R2: When immediate bit 6 (instruction bit 22) is one, the illegal flag is high in the cycle after acceptance, VL, MVL and STATE keep their values, and no write-back occurs.
- R3: With source index 0 and a nonzero destination index, VL and MVL both become imm[5:0] + 1, so an immediate of 0 gives 1.
- R4: An immediate of 63 (binary 111111) gives a length of 64, the largest length the immediate form reaches.
- R5: In immediate mode the write-back strobe is high for one cycle, with the destination index and the new VL zero-extended to the data width.
- R6: With both indices zero, MVL becomes imm[5:0] + 1, VL is unchanged and no write-back occurs.
- R7: With a nonzero source index, VL becomes the smaller of the full-width source value and the current MVL. MVL is unchanged. The write-back carries that value only when the destination index is nonzero.
- R8: The special-register port writes spr_wdata into VL (select 0), MVL (select 1) or STATE (select 2). Any value, zero included, is accepted. Select 3 writes nothing.
- R9: A special-register write takes priority over an instruction update of the same register in the same cycle. The instruction's other effects still take place.
- R10: Every legal accepted instruction clears STATE to zero.
- R11: in_ready is always high. Results appear in the cycle after acceptance. A cycle with in_valid low produces no write-back, no illegal flag and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction fields valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_ra_idx | input | RIDX_W | Source register index |
| in_rt_idx | input | RIDX_W | Destination register index |
| in_ra_val | input | XLEN | Value read from the source register |
| in_imm | input | 7 | Immediate field; bit 6 is reserved |
| spr_we | input | 1 | Special-register write strobe |
| spr_sel | input | 2 | 0 VL, 1 MVL, 2 STATE, 3 none |
| spr_wdata | input | LEN_W | Special-register write data |
| vl | output | LEN_W | Current vector length |
| mvl | output | LEN_W | Current maximum vector length |
| state | output | LEN_W | Current STATE word |
| rt_we | output | 1 | Destination write-back strobe |
| rt_idx | output | RIDX_W | Destination index for write-back |
| rt_data | output | XLEN | Write-back value |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The bench checks both ends of the immediate range. An immediate of 0 must give 1 and an immediate of 63 must give 64; a design that drops the offset would produce 0 or 63. It sets the reserved bit once STATE holds a nonzero value, so a unit that decodes only the low six bits would update the lengths or clear STATE instead of trapping. In register mode the bench drives a source value whose upper bits are set, so a design that compares only the truncated value would fail to clamp it. The same-cycle collision between a special-register write and an instruction, and the zero writes that only the port can make, catch a design with the wrong priority or one that adds the immediate offset to port writes.

// File: rtl/vlset_pkg.sv
package vlset_pkg;

    typedef enum logic [1:0] {
        SPR_VL    = 2'd0,
        SPR_MVL   = 2'd1,
        SPR_STATE = 2'd2,
        SPR_NONE  = 2'd3
    } spr_sel_e;

    typedef enum logic [2:0] {
        FORM_IDLE,
        FORM_TRAP,
        FORM_SETMVL,
        FORM_IMM,
        FORM_REG
    } form_e;

    localparam int IMM_W = 7;

endpackage

// File: rtl/vlset_decode.sv
module vlset_decode
    import vlset_pkg::*;
#(
    parameter int RIDX_W = 5
) (
    input  logic              valid,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [RIDX_W-1:0] rt_idx,
    input  logic [IMM_W-1:0]  imm,
    output form_e             form,
    output logic [IMM_W-1:0]  imm_len
);
    localparam int PAY_W = IMM_W - 1;

    // Offset-by-one length taken from the low six bits; 63 gives 64.
    assign imm_len = {1'b0, imm[PAY_W-1:0]} + IMM_W'(1);

    always_comb begin
        if (!valid)
            form = FORM_IDLE;
        else if (imm[IMM_W-1])
            form = FORM_TRAP;
        else if (ra_idx != '0)
            form = FORM_REG;
        else if (rt_idx == '0)
            form = FORM_SETMVL;
        else
            form = FORM_IMM;
    end
endmodule

// File: rtl/vlset_clamp.sv
module vlset_clamp #(
    parameter int XLEN  = 64,
    parameter int LEN_W = 8
) (
    input  logic [XLEN-1:0]  req,
    input  logic [LEN_W-1:0] limit,
    output logic [LEN_W-1:0] len
);
    // The comparison uses the full source width so large values clamp.
    assign len = (req > XLEN'(limit)) ? limit : req[LEN_W-1:0];
endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
    import vlset_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int LEN_W  = 8,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [RIDX_W-1:0] in_ra_idx,
    input  logic [RIDX_W-1:0] in_rt_idx,
    input  logic [XLEN-1:0]   in_ra_val,
    input  logic [6:0]        in_imm,
    input  logic              spr_we,
    input  logic [1:0]        spr_sel,
    input  logic [LEN_W-1:0]  spr_wdata,
    output logic [LEN_W-1:0]  vl,
    output logic [LEN_W-1:0]  mvl,
    output logic [LEN_W-1:0]  state,
    output logic              rt_we,
    output logic [RIDX_W-1:0] rt_idx,
    output logic [XLEN-1:0]   rt_data,
    output logic              illegal
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        logic [LEN_W-1:0]  vl;
        logic [LEN_W-1:0]  mvl;
        logic [LEN_W-1:0]  state;
        logic              rt_we;
        logic [RIDX_W-1:0] rt_idx;
        logic [XLEN-1:0]   rt_data;
        logic              illegal;
    } unit_state_t;

    unit_state_t st_d, st_q;
    form_e              form;
    logic [IMM_W-1:0]   imm_len;
    logic [LEN_W-1:0]   ilen;
    logic [LEN_W-1:0]   clamped;
    spr_sel_e           sel;

    vlset_decode #(.RIDX_W(RIDX_W)) u_dec (
        .valid   (in_valid),
        .ra_idx  (in_ra_idx),
        .rt_idx  (in_rt_idx),
        .imm     (in_imm),
        .form    (form),
        .imm_len (imm_len)
    );

    vlset_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_clamp (
        .req   (in_ra_val),
        .limit (st_q.mvl),
        .len   (clamped)
    );

    assign ilen     = LEN_W'(imm_len);
    assign sel      = spr_sel_e'(spr_sel);
    assign in_ready = 1'b1;

    always_comb begin
        st_d         = st_q;
        st_d.rt_we   = 1'b0;
        st_d.rt_idx  = '0;
        st_d.rt_data = '0;
        st_d.illegal = 1'b0;

        unique case (form)
            FORM_TRAP: st_d.illegal = 1'b1;
            FORM_SETMVL: begin
                st_d.mvl   = ilen;
                st_d.state = '0;
            end
            FORM_IMM: begin
                st_d.vl      = ilen;
                st_d.mvl     = ilen;
                st_d.state   = '0;
                st_d.rt_we   = 1'b1;
                st_d.rt_idx  = in_rt_idx;
                st_d.rt_data = XLEN'(ilen);
            end
            FORM_REG: begin
                st_d.vl    = clamped;
                st_d.state = '0;
                if (in_rt_idx != '0) begin
                    st_d.rt_we   = 1'b1;
                    st_d.rt_idx  = in_rt_idx;
                    st_d.rt_data = XLEN'(clamped);
                end
            end
            default: ;
        endcase

        // Port write last so it overrides the instruction's update.
        if (spr_we) begin
            unique case (sel)
                SPR_VL:    st_d.vl    = spr_wdata;
                SPR_MVL:   st_d.mvl   = spr_wdata;
                SPR_STATE: st_d.state = spr_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.vl      <= LEN_ONE;
            st_q.mvl     <= LEN_ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign vl      = st_q.vl;
    assign mvl     = st_q.mvl;
    assign state   = st_q.state;
    assign rt_we   = st_q.rt_we;
    assign rt_idx  = st_q.rt_idx;
    assign rt_data = st_q.rt_data;
    assign illegal = st_q.illegal;
endmodule

// File: rtl/vlset_chk.sv
module vlset_chk #(
    parameter int LEN_W  = 8,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [RIDX_W-1:0] in_ra_idx,
    input logic [RIDX_W-1:0] in_rt_idx,
    input logic [6:0]        in_imm,
    input logic              spr_we,
    input logic [LEN_W-1:0]  vl,
    input logic [LEN_W-1:0]  mvl,
    input logic [LEN_W-1:0]  state,
    input logic              rt_we,
    input logic              illegal
);
    // R2
    trap_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_imm[6] && !spr_we) |=>
            (illegal && !rt_we && $stable(vl) && $stable(mvl) && $stable(state)));

    // R3
    imm_equal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_imm[6] && in_ra_idx == '0 && in_rt_idx != '0 && !spr_we) |=>
            (vl == mvl && vl != '0 && rt_we));

    // R6
    setmvl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_imm[6] && in_ra_idx == '0 && in_rt_idx == '0 && !spr_we) |=>
            ($stable(vl) && !rt_we && mvl != '0));

    // R7
    reg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_imm[6] && in_ra_idx != '0 && !spr_we) |=>
            (vl <= $past(mvl) && $stable(mvl)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !spr_we) |=>
            (!rt_we && !illegal && $stable(vl) && $stable(mvl) && $stable(state)));
endmodule

bind vlset_unit vlset_chk #(.LEN_W(LEN_W), .RIDX_W(RIDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ra_idx (in_ra_idx),
    .in_rt_idx (in_rt_idx),
    .in_imm    (in_imm),
    .spr_we    (spr_we),
    .vl        (vl),
    .mvl       (mvl),
    .state     (state),
    .rt_we     (rt_we),
    .illegal   (illegal)
);

// File: tb/sim_vlset_unit.sv
`timescale 1ns/1ps
module sim_vlset_unit;
    localparam int XLEN = 64, LEN_W = 8, RIDX_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [RIDX_W-1:0] in_ra_idx = '0, in_rt_idx = '0;
    logic [XLEN-1:0] in_ra_val = '0;
    logic [6:0] in_imm = '0;
    logic spr_we = 1'b0;
    logic [1:0] spr_sel = '0;
    logic [LEN_W-1:0] spr_wdata = '0;
    logic [LEN_W-1:0] vl, mvl, state;
    logic rt_we, illegal;
    logic [RIDX_W-1:0] rt_idx;
    logic [XLEN-1:0] rt_data;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    vlset_unit #(.XLEN(XLEN), .LEN_W(LEN_W), .RIDX_W(RIDX_W)) u0 (.*);

    typedef struct {
        logic [LEN_W-1:0] vl, mvl, state;
        logic rt_we, illegal, ready;
        logic [RIDX_W-1:0] rt_idx;
        logic [XLEN-1:0] rt_data;
        string req;
    } exp_t;

    exp_t q[$];
    logic [LEN_W-1:0] m_vl = 1, m_mvl = 1, m_state = 0;

    // Driver: applies one cycle of stimulus and predicts its result.
    task automatic step(input logic v, input int ra, input int rt, input logic [XLEN-1:0] rv,
                        input logic [6:0] imm, input logic sw, input int ss,
                        input logic [LEN_W-1:0] sd, input string req);
        exp_t e;
        logic [LEN_W-1:0] len;
        @(negedge clk);
        in_valid = v; in_ra_idx = RIDX_W'(ra); in_rt_idx = RIDX_W'(rt);
        in_ra_val = rv; in_imm = imm; spr_we = sw; spr_sel = 2'(ss); spr_wdata = sd;
        e.rt_we = 0; e.illegal = 0; e.rt_idx = '0; e.rt_data = '0; e.req = req; e.ready = 1;
        len = LEN_W'(imm[5:0]) + 1;
        if (v) begin
            if (imm[6]) e.illegal = 1;                         // R2
            else if (ra != 0) begin                            // R7
                len = (rv > XLEN'(m_mvl)) ? m_mvl : rv[LEN_W-1:0];
                m_vl = len; m_state = 0;
                if (rt != 0) begin e.rt_we = 1; e.rt_idx = RIDX_W'(rt); e.rt_data = XLEN'(len); end
            end else if (rt == 0) begin                        // R6
                m_mvl = len; m_state = 0;
            end else begin                                     // R3 R5
                m_vl = len; m_mvl = len; m_state = 0;
                e.rt_we = 1; e.rt_idx = RIDX_W'(rt); e.rt_data = XLEN'(len);
            end
        end
        if (sw) begin                                          // R8 R9
            if (ss == 0) m_vl = sd;
            else if (ss == 1) m_mvl = sd;
            else if (ss == 2) m_state = sd;
        end
        e.vl = m_vl; e.mvl = m_mvl; e.state = m_state;
        q.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: compares one expected item per cycle, just after the edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (vl !== e.vl || mvl !== e.mvl || state !== e.state || rt_we !== e.rt_we ||
                illegal !== e.illegal || in_ready !== e.ready ||
                (e.rt_we && (rt_idx !== e.rt_idx || rt_data !== e.rt_data))) begin
                errors++;
                $display("FAIL %s: act vl=%0d mvl=%0d st=%0d we=%b idx=%0d d=%0d ill=%b rdy=%b exp vl=%0d mvl=%0d st=%0d we=%b idx=%0d d=%0d ill=%b",
                         e.req, vl, mvl, state, rt_we, rt_idx, rt_data, illegal, in_ready,
                         e.vl, e.mvl, e.state, e.rt_we, e.rt_idx, e.rt_data, e.illegal);
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: act timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, 0, 0, 7'h00, 0, 0, 0, "R1 reset");
        step(1, 0, 3, 0, 7'h00, 0, 0, 0, "R3 R5 imm 0 gives 1");
        step(1, 0, 4, 0, 7'h3F, 0, 0, 0, "R4 imm 63 gives 64");
        step(1, 0, 1, 0, 7'h05, 0, 0, 0, "R3 imm 5 gives 6");
        step(0, 0, 0, 0, 7'h00, 1, 2, 8'd5, "R8 state write");
        step(1, 0, 2, 0, 7'h45, 0, 0, 0, "R2 reserved bit traps");
        step(1, 0, 0, 0, 7'd19, 0, 0, 0, "R6 R10 set mvl only");
        step(1, 2, 7, 64'd100, 7'h00, 0, 0, 0, "R7 clamp to mvl");
        step(1, 2, 0, 64'd9, 7'h00, 0, 0, 0, "R7 no writeback rt0");
        step(1, 3, 6, 64'hFFFF_0000_0000_0003, 7'h00, 0, 0, 0, "R7 wide source clamps");
        step(0, 0, 0, 0, 7'h00, 1, 0, 8'd0, "R8 vl zero");
        step(0, 0, 0, 0, 7'h00, 1, 1, 8'd0, "R8 mvl zero");
        step(0, 0, 0, 0, 7'h00, 1, 3, 8'd77, "R8 select 3 ignored");
        step(1, 0, 5, 0, 7'd9, 1, 0, 8'd33, "R9 port wins vl");
        step(0, 0, 0, 0, 7'h00, 1, 2, 8'd3, "R8 state write");
        step(0, 0, 9, 0, 7'h7F, 0, 0, 0, "R11 invalid ignored");
        step(1, 4, 8, 64'd10, 7'h00, 0, 0, 0, "R7 R10 equal to mvl");
        step(1, 4, 8, 64'd11, 7'h00, 1, 1, 8'd40, "R9 port mvl with reg");
        step(0, 0, 0, 0, 7'h00, 0, 0, 0, "R11 idle");
        @(negedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R11: act %0d pending exp 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule